// File: doc/BRIEF.md
# Lockable Fully Associative Instruction Page Translator

This block turns 32-bit instruction fetch addresses into physical addresses through a small translation cache. Every resident entry is compared with the request in parallel. Pages are a fixed 4 KB, so bits [31:12] of the address are translated and bits [11:0] are carried through unchanged. Each entry holds a virtual page, a physical page, a 4-bit domain, two permission bits and four attribute bits.

On a miss the block asks an external table walker for the page descriptor and writes it into a victim entry. It then repeats the lookup, so the result always comes from the entry that was just written. A fault from the walker ends the request with an abort and writes no entry. Victims are chosen round-robin. The search skips any entry whose lock bit is set, and only the last entry has no lock bit. An invalidate pulse empties every entry that is not locked. A domain control word gives each domain no access, checked access or unchecked access. When translation is disabled, the address passes straight through and no abort is raised.

Top module: `itrans_tlb`

## Requirements
- R1: After reset no entry is valid, `req_ready` is 1, `rsp_valid` and `walk_req_valid` are 0, and the round-robin pointer is at entry 0.
- R2: A request whose page is resident completes with no walk. `rsp_valid` is high for exactly one cycle, two clock edges after the accepting edge. `rsp_pa` = {stored physical page, request bits [11:0]} and `rsp_attr` = stored attributes.
- R3: On a miss, `walk_req_valid` rises with `walk_req_vpn` = request bits [31:12`]` and stays high with a stable page until `walk_rsp_valid`. The descriptor is then stored and the lookup is repeated, so the response is built from the new entry.
- R4: Each fill writes the entry at the round-robin pointer, or the first unlocked entry after it in ascending order with wrap-around. The pointer then moves to the entry after the one filled. The pointer changes only on a fill, so the 33rd distinct page evicts entry 0.
- R5: `lock_mask` bit i (0..30) keeps entry i from being chosen as a victim. Entry 31 is always replaceable, so with all 31 bits set every miss refills entry 31.
- R6: A one-cycle `inval_all` makes every unlocked entry invalid. Locked entries stay valid.
- R7: The domain field selects bits [2d+1:2d] of `dom_ctl`. The value 11 allows access without a permission check. The values 00 and 10 abort. An aborted response has `rsp_abort`=1, `rsp_pa`=0 and `rsp_attr`=0. The control word is applied at lookup time, including lookups on resident entries.
- R8: With domain value 01, permission bit 0 grants access to privileged requests (`req_user`=0) and permission bit 1 grants access to user requests. A request without the matching bit aborts.
- R9: A walk response with `walk_rsp_fault`=1 ends the request with an abort and fills nothing, so the next request to that page walks again.
- R10: When `xlat_en` is 0 at acceptance, the response comes one edge after acceptance with `rsp_pa` = `req_va`, `rsp_attr`=0 and `rsp_abort`=0, and no walk occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xlat_en | input | 1 | Translation enable, sampled at acceptance |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block idle, request accepted this edge |
| req_va | input | 32 | Virtual fetch address |
| req_user | input | 1 | 1 = user-mode fetch, 0 = privileged |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_pa | output | 32 | Physical address (0 on abort) |
| rsp_attr | output | 4 | Cache attributes (0 on abort) |
| rsp_abort | output | 1 | Prefetch abort |
| walk_req_valid | output | 1 | Descriptor request, held until answered |
| walk_req_vpn | output | 20 | Page being walked |
| walk_rsp_valid | input | 1 | Descriptor available |
| walk_rsp_fault | input | 1 | Walk failed |
| walk_rsp_ppn | input | 20 | Physical page from descriptor |
| walk_rsp_dom | input | 4 | Domain from descriptor |
| walk_rsp_ap | input | 2 | Permission bits: [0] privileged, [1] user |
| walk_rsp_attr | input | 4 | Attributes from descriptor |
| lock_mask | input | 31 | Per-entry lock for entries 0..30 |
| inval_all | input | 1 | Invalidate all unlocked entries |
| dom_ctl | input | 32 | Two bits of access control per domain |

## Verification
The hardest state to reach from the ports is a buffer in which every lockable entry is both filled and locked, so that the victim search has to wrap around to entry 31. The bench reaches it by filling all 32 entries with distinct pages, then setting all 31 lock bits. It then sends misses and shows that they evict only the page in entry 31. Eviction is observed only through whether a later request raises a walk, so each scenario is built from a known reset state with a precomputed fill order.

// File: rtl/xtlb_pkg.sv
package xtlb_pkg;
    localparam int VA_W   = 32;
    localparam int PG_OFF = 12;
    localparam int VPN_W  = VA_W - PG_OFF;
    localparam int PPN_W  = 20;
    localparam int PA_W   = PPN_W + PG_OFF;
    localparam int DOM_W  = 4;
    localparam int NDOM   = 1 << DOM_W;
    localparam int AP_W   = 2;
    localparam int ATTR_W = 4;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [PPN_W-1:0]  ppn;
        logic [DOM_W-1:0]  dom;
        logic [AP_W-1:0]   ap;
        logic [ATTR_W-1:0] attr;
    } xtlb_ent_t;

    typedef enum logic [1:0] {
        XS_IDLE = 2'd0,
        XS_LOOK = 2'd1,
        XS_WALK = 2'd2,
        XS_RESP = 2'd3
    } xtlb_st_t;
endpackage

// File: rtl/xtlb_victim.sv
module xtlb_victim #(
    parameter int N  = 32,
    localparam int IW = $clog2(N)
) (
    input  logic [IW-1:0] rr_ptr,
    input  logic [N-1:0]  lock_vec,
    output logic [IW-1:0] victim
);
    int         pos;
    logic       found;
    logic [IW-1:0] cand;

    // first unlocked slot at or after the pointer, wrapping
    always_comb begin
        victim = IW'(N - 1);
        found  = 1'b0;
        pos    = 0;
        cand   = '0;
        for (int k = 0; k < N; k++) begin
            pos = int'(rr_ptr) + k;
            if (pos >= N) pos = pos - N;
            cand = IW'(pos);
            if (!found && !lock_vec[cand]) begin
                found  = 1'b1;
                victim = cand;
            end
        end
    end
endmodule

// File: rtl/xtlb_perm.sv
module xtlb_perm
    import xtlb_pkg::*;
(
    input  logic [2*NDOM-1:0] dom_ctl,
    input  logic [DOM_W-1:0]  dom,
    input  logic [AP_W-1:0]   ap,
    input  logic              user,
    output logic              allow
);
    logic [1:0] field;

    always_comb begin
        field = dom_ctl[{dom, 1'b0} +: 2];
        case (field)
            2'b11:   allow = 1'b1;
            2'b01:   allow = user ? ap[1] : ap[0];
            default: allow = 1'b0;
        endcase
    end
endmodule

// File: rtl/xtlb_array.sv
module xtlb_array
    import xtlb_pkg::*;
#(
    parameter int N  = 32,
    localparam int IW = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VPN_W-1:0]  look_vpn,
    output logic              hit,
    output logic [PPN_W-1:0]  hit_ppn,
    output logic [DOM_W-1:0]  hit_dom,
    output logic [AP_W-1:0]   hit_ap,
    output logic [ATTR_W-1:0] hit_attr,
    input  logic              fill_we,
    input  logic [IW-1:0]     fill_idx,
    input  xtlb_ent_t         fill_ent,
    input  logic              inval_all,
    input  logic [N-1:0]      lock_vec
);
    typedef struct packed {
        logic [N-1:0]           vld;
        xtlb_ent_t [N-1:0]      ent;
    } arr_t;

    arr_t         s_d, s_q;
    logic [N-1:0] match;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = s_q.vld[g] && (s_q.ent[g].vpn == look_vpn);
    end

    // lowest matching index wins
    always_comb begin
        hit      = 1'b0;
        hit_ppn  = '0;
        hit_dom  = '0;
        hit_ap   = '0;
        hit_attr = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit      = 1'b1;
                hit_ppn  = s_q.ent[i].ppn;
                hit_dom  = s_q.ent[i].dom;
                hit_ap   = s_q.ent[i].ap;
                hit_attr = s_q.ent[i].attr;
            end
        end
    end

    always_comb begin
        s_d = s_q;
        if (inval_all) s_d.vld = s_q.vld & lock_vec;
        if (fill_we) begin
            s_d.vld[fill_idx] = 1'b1;
            s_d.ent[fill_idx] = fill_ent;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assert_fill_unlocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fill_we |-> !lock_vec[fill_idx]);

    assert_lock_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        inval_all |=> ((s_q.vld & $past(lock_vec & s_q.vld)) == $past(lock_vec & s_q.vld)));

    assert_single_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
endmodule

// File: rtl/itrans_tlb.sv
module itrans_tlb
    import xtlb_pkg::*;
#(
    parameter int ENTRIES = 32,
    localparam int IW = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xlat_en,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_va,
    input  logic              req_user,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_pa,
    output logic [ATTR_W-1:0] rsp_attr,
    output logic              rsp_abort,
    output logic              walk_req_valid,
    output logic [VPN_W-1:0]  walk_req_vpn,
    input  logic              walk_rsp_valid,
    input  logic              walk_rsp_fault,
    input  logic [PPN_W-1:0]  walk_rsp_ppn,
    input  logic [DOM_W-1:0]  walk_rsp_dom,
    input  logic [AP_W-1:0]   walk_rsp_ap,
    input  logic [ATTR_W-1:0] walk_rsp_attr,
    input  logic [ENTRIES-2:0] lock_mask,
    input  logic              inval_all,
    input  logic [2*NDOM-1:0] dom_ctl
);
    typedef struct packed {
        xtlb_st_t          st;
        logic [VA_W-1:0]   va;
        logic              user;
        logic              xen;
        logic [IW-1:0]     rr;
        logic [PA_W-1:0]   pa;
        logic [ATTR_W-1:0] attr;
        logic              abort;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [ENTRIES-1:0] lock_vec;
    logic               hit, allow, fill_we;
    logic [PPN_W-1:0]   hit_ppn;
    logic [DOM_W-1:0]   hit_dom;
    logic [AP_W-1:0]    hit_ap;
    logic [ATTR_W-1:0]  hit_attr;
    logic [IW-1:0]      victim;
    xtlb_ent_t          fill_ent;

    // the last slot carries no lock bit, so a victim always exists
    assign lock_vec = {1'b0, lock_mask};

    assign fill_ent = '{vpn:  c_q.va[VA_W-1:PG_OFF],
                        ppn:  walk_rsp_ppn,
                        dom:  walk_rsp_dom,
                        ap:   walk_rsp_ap,
                        attr: walk_rsp_attr};

    xtlb_array #(.N(ENTRIES)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .look_vpn (c_q.va[VA_W-1:PG_OFF]),
        .hit      (hit),
        .hit_ppn  (hit_ppn),
        .hit_dom  (hit_dom),
        .hit_ap   (hit_ap),
        .hit_attr (hit_attr),
        .fill_we  (fill_we),
        .fill_idx (victim),
        .fill_ent (fill_ent),
        .inval_all(inval_all),
        .lock_vec (lock_vec)
    );

    xtlb_victim #(.N(ENTRIES)) u_victim (
        .rr_ptr  (c_q.rr),
        .lock_vec(lock_vec),
        .victim  (victim)
    );

    xtlb_perm u_perm (
        .dom_ctl(dom_ctl),
        .dom    (hit_dom),
        .ap     (hit_ap),
        .user   (c_q.user),
        .allow  (allow)
    );

    always_comb begin
        c_d     = c_q;
        fill_we = 1'b0;
        case (c_q.st)
            XS_IDLE: begin
                if (req_valid) begin
                    c_d.va   = req_va;
                    c_d.user = req_user;
                    c_d.xen  = xlat_en;
                    if (!xlat_en) begin
                        c_d.pa    = PA_W'(req_va);
                        c_d.attr  = '0;
                        c_d.abort = 1'b0;
                        c_d.st    = XS_RESP;
                    end else begin
                        c_d.st = XS_LOOK;
                    end
                end
            end
            XS_LOOK: begin
                if (hit) begin
                    c_d.st = XS_RESP;
                    if (allow) begin
                        c_d.pa    = {hit_ppn, c_q.va[PG_OFF-1:0]};
                        c_d.attr  = hit_attr;
                        c_d.abort = 1'b0;
                    end else begin
                        c_d.pa    = '0;
                        c_d.attr  = '0;
                        c_d.abort = 1'b1;
                    end
                end else begin
                    c_d.st = XS_WALK;
                end
            end
            XS_WALK: begin
                if (walk_rsp_valid) begin
                    if (walk_rsp_fault) begin
                        c_d.pa    = '0;
                        c_d.attr  = '0;
                        c_d.abort = 1'b1;
                        c_d.st    = XS_RESP;
                    end else begin
                        fill_we = 1'b1;
                        c_d.rr  = (victim == IW'(ENTRIES - 1)) ? '0 : victim + 1'b1;
                        c_d.st  = XS_LOOK;
                    end
                end
            end
            default: c_d.st = XS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign req_ready      = (c_q.st == XS_IDLE);
    assign rsp_valid      = (c_q.st == XS_RESP);
    assign walk_req_valid = (c_q.st == XS_WALK);
    assign walk_req_vpn   = c_q.va[VA_W-1:PG_OFF];
    assign rsp_pa         = c_q.pa;
    assign rsp_attr       = c_q.attr;
    assign rsp_abort      = c_q.abort;

    assert_walk_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req_valid && !walk_rsp_valid) |=> (walk_req_valid && $stable(walk_req_vpn)));

    assert_rsp_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    assert_offset_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_abort && c_q.xen) |-> (rsp_pa[PG_OFF-1:0] == c_q.va[PG_OFF-1:0]));

    assert_bypass_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !c_q.xen) |-> (rsp_pa == PA_W'(c_q.va) && !rsp_abort));

    assert_rr_still_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_we |=> $stable(c_q.rr));

    assert_abort_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_abort) |-> (rsp_pa == '0 && rsp_attr == '0));

    assert_fault_nofill_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req_valid && walk_rsp_valid && walk_rsp_fault) |-> !fill_we);
endmodule

// File: tb/itrans_tlb_tb.sv
module itrans_tlb_tb;
    import xtlb_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int N = 32;
    localparam logic [19:0] PPN_KEY = 20'h5A3C1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xlat_en = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic        req_user = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_pa;
    logic [3:0]  rsp_attr;
    logic        rsp_abort;
    logic        walk_req_valid;
    logic [19:0] walk_req_vpn;
    logic        walk_rsp_valid = 1'b0;
    logic        walk_rsp_fault = 1'b0;
    logic [19:0] walk_rsp_ppn = '0;
    logic [3:0]  walk_rsp_dom = '0;
    logic [1:0]  walk_rsp_ap = '0;
    logic [3:0]  walk_rsp_attr = '0;
    logic [N-2:0] lock_mask = '0;
    logic        inval_all = 1'b0;
    logic [31:0] dom_ctl = 32'hFFFF_FFFF;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    itrans_tlb u_dut (
        .clk(clk), .rst_n(rst_n), .xlat_en(xlat_en),
        .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va), .req_user(req_user),
        .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_attr(rsp_attr), .rsp_abort(rsp_abort),
        .walk_req_valid(walk_req_valid), .walk_req_vpn(walk_req_vpn),
        .walk_rsp_valid(walk_rsp_valid), .walk_rsp_fault(walk_rsp_fault),
        .walk_rsp_ppn(walk_rsp_ppn), .walk_rsp_dom(walk_rsp_dom),
        .walk_rsp_ap(walk_rsp_ap), .walk_rsp_attr(walk_rsp_attr),
        .lock_mask(lock_mask), .inval_all(inval_all), .dom_ctl(dom_ctl)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // descriptor fields are a fixed function of the page
    function automatic bit model_abort(input logic [19:0] vpn, input bit user);
        logic [1:0] f;
        f = dom_ctl[{vpn[3:0], 1'b0} +: 2];
        case (f)
            2'b11:   return 1'b0;
            2'b01:   return user ? !vpn[5] : !vpn[4];
            default: return 1'b1;
        endcase
    endfunction

    task automatic xlat(input logic [31:0] va, input bit user, input bit fault,
                        input bit exp_walk, input string tag);
        logic [19:0] vpn;
        bit walked;
        bit got;
        int lat;
        bit exp_ab;
        logic [31:0] exp_pa;
        logic [3:0] exp_attr;
        vpn = va[31:12];
        walked = 1'b0;
        got = 1'b0;
        @(negedge clk);
        req_va = va;
        req_user = user;
        req_valid = 1'b1;
        chk({tag, " ready"}, req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!got && lat < 60) begin
            if (rsp_valid) begin
                got = 1'b1;
                walk_rsp_valid = 1'b0;
            end else begin
                if (walk_req_valid && !walk_rsp_valid) begin
                    walked = 1'b1;
                    chk({tag, " walk page"}, walk_req_vpn, vpn);
                    walk_rsp_valid = 1'b1;
                    walk_rsp_fault = fault;
                    walk_rsp_ppn = vpn ^ PPN_KEY;
                    walk_rsp_dom = vpn[3:0];
                    walk_rsp_ap = vpn[5:4];
                    walk_rsp_attr = vpn[9:6];
                end else begin
                    walk_rsp_valid = 1'b0;
                end
                @(negedge clk);
                lat++;
            end
        end
        walk_rsp_valid = 1'b0;
        walk_rsp_fault = 1'b0;
        if (!got) begin
            chk({tag, " response timeout"}, 0, 1);
        end else begin
            if (!xlat_en) begin
                exp_ab = 1'b0; exp_pa = va; exp_attr = '0;
            end else begin
                exp_ab = fault ? 1'b1 : model_abort(vpn, user);
                exp_pa = exp_ab ? 32'h0 : {vpn ^ PPN_KEY, va[11:0]};
                exp_attr = exp_ab ? 4'h0 : vpn[9:6];
            end
            chk({tag, " walk seen"}, walked, exp_walk);
            chk({tag, " abort"}, rsp_abort, exp_ab);
            chk({tag, " pa"}, rsp_pa, exp_pa);
            chk({tag, " attr"}, rsp_attr, exp_attr);
            if (!walked) chk({tag, " latency"}, lat, xlat_en ? 2 : 1);
            @(negedge clk);
            chk({tag, " strobe one cycle"}, rsp_valid, 0);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic pulse_inval();
        @(negedge clk);
        inval_all = 1'b1;
        @(negedge clk);
        inval_all = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R1 ready after reset", req_ready, 1);
        chk("R1 no response after reset", rsp_valid, 0);
        chk("R1 no walk after reset", walk_req_valid, 0);
    endtask

    task automatic t_hit_miss();
        do_reset();
        dom_ctl = 32'hFFFF_FFFF;
        xlat(32'h1234_5678, 1'b0, 1'b0, 1'b1, "R1 R3 empty buffer miss");
        xlat(32'h1234_5ABC, 1'b1, 1'b0, 1'b0, "R2 resident hit");
        xlat(32'h0ACE_1001, 1'b0, 1'b0, 1'b1, "R3 second page miss");
        xlat(32'h0ACE_1FFF, 1'b0, 1'b0, 1'b0, "R2 second page hit");
        xlat(32'h1234_5000, 1'b0, 1'b0, 1'b0, "R2 first page still hits");
    endtask

    task automatic t_round_robin();
        do_reset();
        dom_ctl = 32'hFFFF_FFFF;
        for (int i = 0; i < N; i++)
            xlat({20'h80000 + 20'(i), 12'h010}, 1'b0, 1'b0, 1'b1, "R4 fill all");
        xlat({20'h80020, 12'h0}, 1'b0, 1'b0, 1'b1, "R4 wrap evicts slot 0");
        xlat({20'h80001, 12'h0}, 1'b0, 1'b0, 1'b0, "R4 slot 1 kept");
        xlat({20'h8001F, 12'h0}, 1'b0, 1'b0, 1'b0, "R4 slot 31 kept");
        xlat({20'h80000, 12'h0}, 1'b0, 1'b0, 1'b1, "R4 evicted page walks");
        xlat({20'h80001, 12'h0}, 1'b0, 1'b0, 1'b1, "R4 next victim slot 1");
    endtask

    task automatic t_lock_inval();
        do_reset();
        dom_ctl = 32'hFFFF_FFFF;
        for (int i = 0; i < N; i++)
            xlat({20'h90000 + 20'(i), 12'h0}, 1'b0, 1'b0, 1'b1, "R5 fill all");
        lock_mask = '1;
        xlat({20'hA0000, 12'h0}, 1'b0, 1'b0, 1'b1, "R5 miss takes slot 31");
        xlat({20'h90005, 12'h0}, 1'b0, 1'b0, 1'b0, "R5 locked slot kept");
        xlat({20'h9001F, 12'h0}, 1'b0, 1'b0, 1'b1, "R5 slot 31 was replaced");
        xlat({20'hA0000, 12'h0}, 1'b0, 1'b0, 1'b1, "R5 slot 31 replaced again");
        pulse_inval();
        xlat({20'h90000, 12'h0}, 1'b0, 1'b0, 1'b0, "R6 locked survives invalidate");
        xlat({20'h9001E, 12'h0}, 1'b0, 1'b0, 1'b0, "R6 locked slot 30 survives");
        xlat({20'hA0000, 12'h0}, 1'b0, 1'b0, 1'b1, "R6 unlocked slot cleared");
        lock_mask = '0;
        lock_mask[3] = 1'b1;
        pulse_inval();
        xlat({20'h90003, 12'h0}, 1'b0, 1'b0, 1'b0, "R6 single lock survives");
        xlat({20'h90004, 12'h0}, 1'b0, 1'b0, 1'b1, "R6 neighbour cleared");
        lock_mask = '0;
    endtask

    task automatic t_domain();
        do_reset();
        // domain0=00, domain1=01, domain2=10, domain3=11
        dom_ctl = 32'h0000_00E4;
        xlat({20'hB0030, 12'h004}, 1'b0, 1'b0, 1'b1, "R7 domain value 00 aborts");
        xlat({20'hB0032, 12'h004}, 1'b0, 1'b0, 1'b1, "R7 domain value 10 aborts");
        xlat({20'hB0003, 12'h008}, 1'b1, 1'b0, 1'b1, "R7 domain value 11 skips check");
        xlat({20'hB0011, 12'h00C}, 1'b0, 1'b0, 1'b1, "R8 privileged bit grants");
        xlat({20'hB0011, 12'h00C}, 1'b1, 1'b0, 1'b0, "R8 user denied on hit");
        xlat({20'hB0021, 12'h0F0}, 1'b1, 1'b0, 1'b1, "R8 user bit grants");
        xlat({20'hB0021, 12'h0F0}, 1'b0, 1'b0, 1'b0, "R8 privileged denied on hit");
        dom_ctl = 32'hFFFF_FFFF;
        xlat({20'hB0030, 12'h004}, 1'b0, 1'b0, 1'b0, "R7 new control applies to resident");
    endtask

    task automatic t_fault();
        do_reset();
        dom_ctl = 32'hFFFF_FFFF;
        xlat({20'hC0000, 12'h123}, 1'b0, 1'b1, 1'b1, "R9 faulting walk aborts");
        xlat({20'hC0000, 12'h123}, 1'b0, 1'b0, 1'b1, "R9 no fill after fault");
        xlat({20'hC0000, 12'h456}, 1'b0, 1'b0, 1'b0, "R9 later fill resident");
    endtask

    task automatic t_disable();
        do_reset();
        dom_ctl = 32'h0;
        xlat_en = 1'b0;
        xlat(32'hDEAD_BEEF, 1'b1, 1'b0, 1'b0, "R10 bypass no abort");
        xlat(32'h0000_1234, 1'b0, 1'b0, 1'b0, "R10 bypass second address");
        xlat_en = 1'b1;
        xlat(32'h0000_1234, 1'b0, 1'b0, 1'b1, "R10 enabled again translates");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_hit_miss();
        t_round_robin();
        t_lock_inval();
        t_domain();
        t_fault();
        t_disable();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule